// File: doc/BRIEF.md
# Interrupt Source Masking Register Bank

This block gathers 32 level-sensitive hardware interrupt lines and a software-settable request word into one raw request vector. It applies a software-controlled enable mask and a per-source routing mask. The routing mask steers each source either to the normal request path or to the fast request path. The block exports the masked normal-path vector to a downstream priority resolver, exports the fast-path vector, and drives a single active-high fast-request output.

Software reaches the bank through a simple word-addressed register bus. A write strobe commits on the rising clock edge. Read data follows the address combinationally. The enable mask and the software request word each have two write addresses: one sets bits and one clears bits, so that a read-modify-write is never needed. The hardware lines are registered once, so every status view reflects the levels sampled on the previous edge.

Top module: `irq_src_bank`

## Requirements
- R1: Raw status, read at word offset 2, is the bitwise OR of the hardware lines registered on the previous clock edge and the software request word.
- R2: Normal-path status is raw AND enable AND NOT route. It is read at word offset 0 and driven on `irq_status`.
- R3: Fast-path status is raw AND route. It is read at word offset 1 and driven on `fiq_status`. The enable mask has no effect on it.
- R4: `fiq_out` is high exactly when at least one bit of raw AND route is set, whatever the enable mask holds.
- R5: A write to word offset 4 ORs the data into the enable mask. A write to offset 5 clears each enable bit where the data bit is 1. Offset 4 reads the mask, and offset 5 reads zero.
- R6: A write to word offset 6 ORs the data into the software request word. A write to offset 7 clears each of its bits where the data bit is 1. Offset 6 reads the word, and offset 7 reads zero.
- R7: Word offset 3 holds the route mask (1 = fast path), which is loaded and read directly.
- R8: Word offset 8 stores data bit 0 as a protection flag and reads it back in bit 0 with the upper bits zero. The flag changes no status and no output.
- R9: Writes to the status offsets 0, 1 and 2, and to unmapped offsets, change no register.
- R10: Synchronous active-low reset clears the enable mask, the route mask, the software word, the protection flag and the sampled hardware lines. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 32 | Hardware interrupt levels, active high |
| bus_wr | input | 1 | Write strobe, committed at the rising edge |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_status | output | 32 | Masked normal-path status |
| fiq_status | output | 32 | Fast-path status |
| fiq_out | output | 1 | Fast request, active high |

## Verification
The bench targets the points where separate controls interact. A source that is routed to the fast path while its enable bit is clear must still raise `fiq_out`; a design that gated the fast path by enable would drop that request. A set-write and a clear-write must leave every unaddressed bit untouched; a design that loaded the data plainly would wipe the other sources. Writes to the status offsets and to the protection flag must leave every output unchanged, and status must lag the input lines by exactly one edge; an unregistered or doubly registered path would show the wrong cycle's level.

// File: rtl/irq_bank_pkg.sv
// Package: word offsets of the register bank. Software decodes these
// offsets, so they are fixed; everything else is local to the design.
package irq_bank_pkg;
    localparam int OFS_IRQ_STAT = 0;
    localparam int OFS_FIQ_STAT = 1;
    localparam int OFS_RAW_STAT = 2;
    localparam int OFS_ROUTE    = 3;
    localparam int OFS_EN_SET   = 4;
    localparam int OFS_EN_CLR   = 5;
    localparam int OFS_SW_SET   = 6;
    localparam int OFS_SW_CLR   = 7;
    localparam int OFS_PROT     = 8;

    // Kind of update a mask register performs on a write
    typedef enum logic {
        UPD_SETCLR = 1'b0,
        UPD_LOAD   = 1'b1
    } upd_kind_e;
endpackage

// File: rtl/irq_sync_stage.sv
// Module: irq_sync_stage
// Registers the hardware interrupt levels once per clock.
// Assumes the inputs are already in the clk domain; no metastability
// filtering is done here.
module irq_sync_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_in,
    output logic [W-1:0] lvl_q
);
    // Capture the input levels; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_in;
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Module: irq_mask_reg
// Holds a bit mask that is updated either by separate set and clear
// strobes (write-one-to-set / write-one-to-clear) or by a plain load.
// Assumes at most one strobe is active in a cycle; with UPD_SETCLR a
// set strobe wins if both are raised.
module irq_mask_reg
    import irq_bank_pkg::*;
#(
    parameter int        W    = 32,
    parameter upd_kind_e KIND = UPD_SETCLR
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    generate
        if (KIND == UPD_SETCLR) begin : g_setclr
            // Next value: OR in ones on set, knock out ones on clear
            always_comb begin
                nxt = q;
                if (set_stb)      nxt = q | wdata;
                else if (clr_stb) nxt = q & ~wdata;
            end
        end else begin : g_load
            logic unused_clr;
            assign unused_clr = clr_stb;
            // Next value: direct load on the set strobe
            always_comb begin
                nxt = q;
                if (set_stb) nxt = wdata;
            end
        end
    endgenerate

    // State register with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/irq_route.sv
// Module: irq_route
// Combines sampled hardware levels with the software word into raw
// status, then splits it into the normal path (gated by enable) and
// the fast path (selected by route, never gated by enable).
module irq_route #(
    parameter int W = 32
) (
    input  logic [W-1:0] hw_q,
    input  logic [W-1:0] sw_q,
    input  logic [W-1:0] en_q,
    input  logic [W-1:0] route_q,
    output logic [W-1:0] raw,
    output logic [W-1:0] irq_vec,
    output logic [W-1:0] fiq_vec,
    output logic         fiq_any
);
    // Form raw, per-path status and the fast-request reduction
    always_comb begin
        raw     = hw_q | sw_q;
        irq_vec = raw & en_q & ~route_q;
        fiq_vec = raw & route_q;
        fiq_any = |fiq_vec;
    end
endmodule

// File: rtl/irq_src_bank.sv
// Module: irq_src_bank (top)
// Register bank for interrupt source masking and routing. Decodes the
// word-addressed bus, holds enable, route, software and protection
// state, and exports status vectors and the fast-request output.
// Assumes writes commit on the clock edge and reads are combinational.
module irq_src_bank
    import irq_bank_pkg::*;
#(
    parameter int SRC_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src_lvl,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SRC_W-1:0]  bus_wdata,
    output logic [SRC_W-1:0]  bus_rdata,
    output logic [SRC_W-1:0]  irq_status,
    output logic [SRC_W-1:0]  fiq_status,
    output logic              fiq_out
);
    localparam int OFS_COUNT = 1 << ADDR_W;

    logic [SRC_W-1:0] hw_q, sw_q, en_q, route_q, raw;
    logic [0:0]       prot_q;
    logic [OFS_COUNT-1:0] wsel;

    // One-hot write decode of the addressed word offset
    always_comb begin
        wsel = '0;
        if (bus_wr) wsel[bus_addr] = 1'b1;
    end

    irq_sync_stage #(.W(SRC_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .lvl_in(src_lvl), .lvl_q(hw_q)
    );

    irq_mask_reg #(.W(SRC_W), .KIND(UPD_SETCLR)) u_en (
        .clk(clk), .rst_n(rst_n),
        .set_stb(wsel[OFS_EN_SET]), .clr_stb(wsel[OFS_EN_CLR]),
        .wdata(bus_wdata), .q(en_q)
    );

    irq_mask_reg #(.W(SRC_W), .KIND(UPD_SETCLR)) u_sw (
        .clk(clk), .rst_n(rst_n),
        .set_stb(wsel[OFS_SW_SET]), .clr_stb(wsel[OFS_SW_CLR]),
        .wdata(bus_wdata), .q(sw_q)
    );

    irq_mask_reg #(.W(SRC_W), .KIND(UPD_LOAD)) u_route (
        .clk(clk), .rst_n(rst_n),
        .set_stb(wsel[OFS_ROUTE]), .clr_stb(1'b0),
        .wdata(bus_wdata), .q(route_q)
    );

    irq_mask_reg #(.W(1), .KIND(UPD_LOAD)) u_prot (
        .clk(clk), .rst_n(rst_n),
        .set_stb(wsel[OFS_PROT]), .clr_stb(1'b0),
        .wdata(bus_wdata[0:0]), .q(prot_q)
    );

    irq_route #(.W(SRC_W)) u_route_logic (
        .hw_q(hw_q), .sw_q(sw_q), .en_q(en_q), .route_q(route_q),
        .raw(raw), .irq_vec(irq_status), .fiq_vec(fiq_status),
        .fiq_any(fiq_out)
    );

    // Read multiplexer; unmapped and write-only offsets return zero
    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            OFS_IRQ_STAT: bus_rdata = irq_status;
            OFS_FIQ_STAT: bus_rdata = fiq_status;
            OFS_RAW_STAT: bus_rdata = raw;
            OFS_ROUTE:    bus_rdata = route_q;
            OFS_EN_SET:   bus_rdata = en_q;
            OFS_SW_SET:   bus_rdata = sw_q;
            OFS_PROT:     bus_rdata[0] = prot_q[0];
            default:      bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_src_bank_chk.sv
// Module: irq_src_bank_chk
// Property checker bound into irq_src_bank. Observes ports and the
// state registers that separate submodules drive.
module irq_src_bank_chk #(
    parameter int SRC_W  = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_W-1:0]  src_lvl,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [SRC_W-1:0]  bus_wdata,
    input logic [SRC_W-1:0]  irq_status,
    input logic [SRC_W-1:0]  fiq_status,
    input logic              fiq_out,
    input logic [SRC_W-1:0]  hw_q,
    input logic [SRC_W-1:0]  en_q,
    input logic [SRC_W-1:0]  sw_q,
    input logic [SRC_W-1:0]  route_q
);
    a_r1_sample_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> hw_q == $past(src_lvl));

    a_r2_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status & ~en_q) == '0);

    a_r3_fiq_only_routed: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_status & ~route_q) == '0);

    a_r4_fiq_out_source: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_out |-> ((hw_q | sw_q) & route_q) != '0);

    a_r5_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && int'(bus_addr) == 4) |=> (en_q & $past(bus_wdata)) == $past(bus_wdata));

    a_r5_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && int'(bus_addr) == 5) |=> (en_q & $past(bus_wdata)) == '0);

    a_r6_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && int'(bus_addr) == 7) |=> (sw_q & $past(bus_wdata)) == '0);

    a_r7_route_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && int'(bus_addr) == 3) |=> route_q == $past(bus_wdata));

    a_r9_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && int'(bus_addr) <= 2) |=> ($stable(en_q) && $stable(sw_q) && $stable(route_q)));
endmodule

bind irq_src_bank irq_src_bank_chk #(.SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_status(irq_status),
    .fiq_status(fiq_status), .fiq_out(fiq_out), .hw_q(hw_q), .en_q(en_q),
    .sw_q(sw_q), .route_q(route_q)
);

// File: tb/irq_src_bank_test.sv
`timescale 1ns/1ps
module irq_src_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_lvl = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, irq_status, fiq_status;
    logic        fiq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state built from the requirements
    logic [31:0] m_hw = '0, m_sw = '0, m_en = '0, m_rt = '0;
    logic        m_prot = 1'b0;

    irq_src_bank uut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_status(irq_status), .fiq_status(fiq_status), .fiq_out(fiq_out)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] exp_raw();
        return m_hw | m_sw;
    endfunction

    function automatic logic [31:0] exp_read(input int ofs);
        case (ofs)
            0: return exp_raw() & m_en & ~m_rt;
            1: return exp_raw() & m_rt;
            2: return exp_raw();
            3: return m_rt;
            4: return m_en;
            6: return m_sw;
            8: return {31'b0, m_prot};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input int ofs);
        case (ofs)
            0: return "R2";
            1: return "R3";
            2: return "R1";
            3: return "R7";
            4, 5: return "R5";
            6, 7: return "R6";
            8: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, commit at posedge, update model
    task automatic cycle(input logic wr, input int ofs, input logic [31:0] d,
                         input logic [31:0] lvl);
        @(negedge clk);
        bus_wr = wr; bus_addr = 4'(ofs); bus_wdata = d; src_lvl = lvl;
        @(posedge clk);
        m_hw = lvl;
        if (wr) begin
            case (ofs)
                3: m_rt = d;
                4: m_en = m_en | d;
                5: m_en = m_en & ~d;
                6: m_sw = m_sw | d;
                7: m_sw = m_sw & ~d;
                8: m_prot = d[0];
                default: ;
            endcase
        end
        #1;
        bus_wr = 1'b0;
    endtask

    // Compare ports and every offset's read data with the model
    task automatic check_all(input string ctx);
        check("R2", {ctx, " irq_status"}, irq_status, exp_read(0));
        check("R3", {ctx, " fiq_status"}, fiq_status, exp_read(1));
        check("R4", {ctx, " fiq_out"}, {31'b0, fiq_out}, {31'b0, |exp_read(1)});
        for (int o = 0; o < 10; o++) begin
            bus_addr = 4'(o);
            #0.1;
            check(tag_of(o), $sformatf("%s read ofs %0d", ctx, o), bus_rdata, exp_read(o));
        end
        bus_addr = 4'd12;
        #0.1;
        check("R10", {ctx, " unmapped read"}, bus_rdata, 32'h0);
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check_all("R10 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R5 set then partial clear leaves other bits
        cycle(1, 4, 32'hF0F0_00FF, '0);
        cycle(1, 5, 32'h0000_000F, '0);
        check("R5", "partial clear keeps others", m_en, 32'hF0F0_00F0);
        check_all("R5 directed");

        // R1 one-edge lag of hardware lines
        cycle(0, 0, 0, 32'h0000_0030);
        check_all("R1 lag");

        // R4 fast path ignores enable: route bit 1, enable bit 1 off
        cycle(1, 3, 32'h0000_0002, 32'h0000_0002);
        check_all("R4 route without enable");
        check("R4", "fiq_out with disabled source", {31'b0, fiq_out}, 32'h1);

        // R6 software set and clear
        cycle(1, 6, 32'h8000_0001, '0);
        check_all("R6 set");
        cycle(1, 7, 32'h8000_0000, '0);
        check_all("R6 clear");

        // R9 status writes ignored
        cycle(1, 0, 32'hFFFF_FFFF, '0);
        cycle(1, 1, 32'hFFFF_FFFF, '0);
        cycle(1, 2, 32'hFFFF_FFFF, '0);
        check_all("R9 status write");

        // R8 protection stores bit 0 only and has no effect
        cycle(1, 8, 32'hFFFF_FFFE, 32'h1);
        check_all("R8 prot upper bits");
        cycle(1, 8, 32'h0000_0001, 32'h1);
        check_all("R8 prot set");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [31:0] d;
            op = int'($urandom_range(0, 12));
            d  = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
            cycle(($urandom_range(0, 4) != 0), op, d, $urandom);
            check_all("random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule